// File: doc/BRIEF.md
# Active Video Timing and Embedded-Sync Generator

This block sits on a pixel-clock video path after sync detection. It counts pixel positions from each horizontal sync leading edge and counts lines from each vertical sync leading edge. From these counts it produces a data-enable flag for the active part of each line and a vertical blanking flag. It also writes digital-video timing codes into the pixel stream: a start-of-active code just before the first active pixel and an end-of-active code just after the last one. Every code carries the field, blanking and code-type bits, plus their protection bits.

A byte-wide write port configures the block. It sets the first and last active pixel, the blanking start offset and blanking length for each of the two fields, and whether data enable is masked during blanking. Pixel data, blanking, data enable and the vertical sync copy all leave the block one clock after the matching input pixel, so they stay aligned with each other.

Top module: `avt_embsync_gen`

## Requirements
- R1: After reset the block uses these settings: first active pixel 0x12C, stop pixel 0x62C, blanking offset 5 and blanking length 30 for both fields, and blanking mask 0. While reset is held, pix_out, de_out, vblank_out and vsync_out are all 0.
- R2: Pixel number 0 is the clock in which hsync_in is first sampled high after being low. Each later clock adds one to the pixel number, which saturates at 8191. Until the first such edge after reset, no code is inserted and data enable stays low. Every output reflects the input pixel of the previous clock.
- R3: The write port uses these addresses: 0 start low byte, 1 start high byte (bits 4:0 hold start bits 12:8, bit 5 holds the blanking mask), 2 stop low byte, 3 stop high byte (bits 4:0), 4 and 5 blanking offset of field 0 and field 1, 6 and 7 blanking length of field 0 and field 1. A write to a low byte is only held in a staging register. The full 13-bit value, together with the mask bit for start, takes effect on the write to the high byte.
- R4: Let the effective stop be stop rounded as R5 describes. de_out is high for pixels from start up to the effective stop minus one, unless R10 masks it.
- R5: When stop minus start is odd, the effective stop is stop plus one, so the active span is always even.
- R6: Pixels start-4 through start-1 carry the start code: all ones, 0x00, 0x00, then a status word with H=0.
- R7: Pixels from the effective stop through the effective stop plus 3 carry the end code: all ones, 0x00, 0x00, then a status word with H=1.
- R8: A status word is laid out as bit7=1, bit6=F, bit5=V, bit4=H, bit3=V^H, bit2=F^H, bit1=F^V, bit0=F^V^H. V is the blanking flag of that pixel.
- R9: The line number is 0 in the clock of the vertical sync leading edge. It goes up by one at each later horizontal sync leading edge; when both edges fall in the same clock, the vertical edge wins. F is field_in sampled at that vertical edge. vblank_out is high while the line number is at least offset[F] and below offset[F]+length[F].
- R10: With the blanking mask at 1, de_out stays low on blanking lines. With the mask at 0, blanking has no effect on de_out.
- R11: vsync_out equals vsync_in delayed by one clock. The blanking settings have no effect on it.
- R12: Pixels that are not code positions pass from pix_in to pix_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| field_in | input | 1 | Field indicator, sampled at the vertical sync leading edge |
| pix_in | input | 8 | Input pixel word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| pix_out | output | 8 | Pixel stream with timing codes inserted |
| de_out | output | 1 | Data enable for the active span |
| vblank_out | output | 1 | Vertical blanking flag |
| vsync_out | output | 1 | Delayed copy of vsync_in |

## Verification
Some cases are rare in normal video timing and hard to reach from the ports. One is a vertical sync edge that lands partway through a line, so the line that contains it becomes line 0. Another is an odd programmed span, which moves the end code. A third is the blanking mask switched on while the field sets use different offsets. The stimulus reaches each of these directly: it raises vertical sync at a chosen pixel of a line, and it programs odd stops and unequal field windows. It also runs randomized frames with random spans, windows, fields, mask values and pixel data. A reference model in the bench follows the edge-counting rules and checks every output pixel.

// File: rtl/avt_pkg.sv
package avt_pkg;

  localparam logic [2:0] RA_START_LO = 3'd0;
  localparam logic [2:0] RA_START_HI = 3'd1;
  localparam logic [2:0] RA_STOP_LO  = 3'd2;
  localparam logic [2:0] RA_STOP_HI  = 3'd3;
  localparam logic [2:0] RA_OFF_F0   = 3'd4;
  localparam logic [2:0] RA_DUR_F0   = 3'd6;

  typedef enum logic [1:0] {
    SLOT_ONES  = 2'd0,
    SLOT_ZERO0 = 2'd1,
    SLOT_ZERO1 = 2'd2,
    SLOT_STAT  = 2'd3
  } code_slot_e;

  // status byte of a timing code with its protection bits
  function automatic logic [7:0] code_status(input logic f, input logic v, input logic h);
    logic [3:0] prot;
    prot[3] = v ^ h;
    prot[2] = f ^ h;
    prot[1] = f ^ v;
    prot[0] = f ^ v ^ h;
    return {1'b1, f, v, h, prot};
  endfunction

endpackage

// File: rtl/avt_regs.sv
module avt_regs #(
  parameter int PW = 13,
  parameter int LW = 8,
  parameter logic [PW-1:0] START_RST = 13'h12C,
  parameter logic [PW-1:0] STOP_RST  = 13'h62C,
  parameter logic [LW-1:0] OFF_RST   = 8'd5,
  parameter logic [LW-1:0] DUR_RST   = 8'd30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [2:0]           addr,
  input  logic [7:0]           wdata,
  output logic [PW-1:0]        start_pos,
  output logic [PW-1:0]        stop_pos,
  output logic                 blank_mask,
  output logic [1:0][LW-1:0]   blank_off,
  output logic [1:0][LW-1:0]   blank_dur
);
  import avt_pkg::*;

  localparam int HI_W = PW - 8;

  logic [7:0] start_stage;
  logic [7:0] stop_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_stage <= START_RST[7:0];
      stop_stage  <= STOP_RST[7:0];
      start_pos   <= START_RST;
      stop_pos    <= STOP_RST;
      blank_mask  <= 1'b0;
    end else if (wr) begin
      case (addr)
        RA_START_LO: start_stage <= wdata;
        RA_STOP_LO:  stop_stage  <= wdata;
        RA_START_HI: begin
          start_pos  <= {wdata[HI_W-1:0], start_stage};
          blank_mask <= wdata[HI_W];
        end
        RA_STOP_HI:  stop_pos <= {wdata[HI_W-1:0], stop_stage};
        default: ;
      endcase
    end
  end

  for (genvar f = 0; f < 2; f++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        blank_off[f] <= OFF_RST;
        blank_dur[f] <= DUR_RST;
      end else if (wr) begin
        if (addr == RA_OFF_F0 + 3'(f)) blank_off[f] <= wdata[LW-1:0];
        if (addr == RA_DUR_F0 + 3'(f)) blank_dur[f] <= wdata[LW-1:0];
      end
    end
  end

endmodule

// File: rtl/avt_hpos.sv
module avt_hpos #(
  parameter int PW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_in,
  output logic          hs_edge,
  output logic [PW-1:0] pos_now
);
  localparam logic [PW-1:0] POS_MAX = {PW{1'b1}};

  logic          hs_q;
  logic [PW-1:0] pos_q;

  function automatic logic [PW-1:0] pos_step(input logic [PW-1:0] p);
    return (p == POS_MAX) ? POS_MAX : p + PW'(1);
  endfunction

  assign hs_edge = hsync_in && !hs_q;
  assign pos_now = hs_edge ? '0 : pos_step(pos_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      pos_q <= POS_MAX;
    end else begin
      hs_q  <= hsync_in;
      pos_q <= pos_now;
    end
  end

endmodule

// File: rtl/avt_vblank.sv
module avt_vblank #(
  parameter int LW = 8,
  localparam int CW = LW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync_in,
  input  logic               field_in,
  input  logic               hs_edge,
  input  logic [1:0][LW-1:0] blank_off,
  input  logic [1:0][LW-1:0] blank_dur,
  output logic               vs_edge,
  output logic               field_now,
  output logic               vblank_now
);
  localparam logic [CW-1:0] LINE_MAX = {CW{1'b1}};

  logic          vs_q;
  logic          field_q;
  logic [CW-1:0] line_q;
  logic [CW-1:0] line_now;
  logic [CW-1:0] win_lo;
  logic [CW-1:0] win_hi;

  function automatic logic [CW-1:0] line_step(input logic [CW-1:0] l);
    return (l == LINE_MAX) ? LINE_MAX : l + CW'(1);
  endfunction

  assign vs_edge   = vsync_in && !vs_q;
  assign field_now = vs_edge ? field_in : field_q;
  assign line_now  = vs_edge ? '0 : (hs_edge ? line_step(line_q) : line_q);

  assign win_lo     = CW'(blank_off[field_now]);
  assign win_hi     = win_lo + CW'(blank_dur[field_now]);
  assign vblank_now = (line_now >= win_lo) && (line_now < win_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q    <= 1'b0;
      field_q <= 1'b0;
      line_q  <= '0;
    end else begin
      vs_q    <= vsync_in;
      field_q <= field_now;
      line_q  <= line_now;
    end
  end

endmodule

// File: rtl/avt_insert.sv
module avt_insert #(
  parameter int PW = 13,
  parameter int DW = 8,
  localparam int EW = PW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pos_now,
  input  logic [PW-1:0] start_pos,
  input  logic [PW-1:0] stop_pos,
  input  logic          blank_mask,
  input  logic          vblank_now,
  input  logic          field_now,
  input  logic          vsync_in,
  input  logic [DW-1:0] pix_in,
  output logic          code_now,
  output logic          status_q,
  output logic [DW-1:0] pix_out,
  output logic          de_out,
  output logic          vblank_out,
  output logic          vsync_out
);
  import avt_pkg::*;

  // stop position after rounding the active span up to an even length
  function automatic logic [PW:0] span_end(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return {1'b0, b} + (PW+1)'(a[0] ^ b[0]);
  endfunction

  logic [EW-1:0] p, s, e;
  logic [EW-1:0] d_eav, d_sav;
  logic          in_eav, in_sav, in_act;
  code_slot_e    slot;
  logic [7:0]    st8;
  logic [DW-1:0] st_word;
  logic [DW-1:0] code_word;
  logic          de_now;

  assign p = EW'(pos_now);
  assign s = EW'(start_pos);
  assign e = EW'(span_end(start_pos, stop_pos));

  assign d_eav = p - e;
  assign d_sav = p - s;

  assign in_eav = (p >= e) && (p < e + EW'(4));
  assign in_sav = (p + EW'(4) >= s) && (p < s);
  assign in_act = (p >= s) && (p < e);

  assign code_now = in_eav || in_sav;
  assign slot     = code_slot_e'(in_eav ? d_eav[1:0] : d_sav[1:0]);
  assign st8      = code_status(field_now, vblank_now, in_eav);

  if (DW == 8) begin : g_st8
    assign st_word = st8;
  end else begin : g_stwide
    assign st_word = {st8, {(DW-8){1'b0}}};
  end

  always_comb begin
    case (slot)
      SLOT_ONES:  code_word = {DW{1'b1}};
      SLOT_STAT:  code_word = st_word;
      default:    code_word = '0;
    endcase
  end

  assign de_now = in_act && !(blank_mask && vblank_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out    <= '0;
      de_out     <= 1'b0;
      vblank_out <= 1'b0;
      vsync_out  <= 1'b0;
      status_q   <= 1'b0;
    end else begin
      pix_out    <= code_now ? code_word : pix_in;
      de_out     <= de_now;
      vblank_out <= vblank_now;
      vsync_out  <= vsync_in;
      status_q   <= code_now && (slot == SLOT_STAT);
    end
  end

endmodule

// File: rtl/avt_embsync_gen.sv
module avt_embsync_gen #(
  parameter int PW = 13,
  parameter int DW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_in,
  input  logic          vsync_in,
  input  logic          field_in,
  input  logic [DW-1:0] pix_in,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [DW-1:0] pix_out,
  output logic          de_out,
  output logic          vblank_out,
  output logic          vsync_out
);

  logic [PW-1:0]      start_pos;
  logic [PW-1:0]      stop_pos;
  logic               blank_mask;
  logic [1:0][LW-1:0] blank_off;
  logic [1:0][LW-1:0] blank_dur;
  logic               hs_edge;
  logic [PW-1:0]      pos_now;
  logic               vs_edge;
  logic               field_now;
  logic               vblank_now;
  logic               code_now;
  logic               status_q;

  avt_regs #(.PW(PW), .LW(LW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .start_pos  (start_pos),
    .stop_pos   (stop_pos),
    .blank_mask (blank_mask),
    .blank_off  (blank_off),
    .blank_dur  (blank_dur)
  );

  avt_hpos #(.PW(PW)) u_hpos (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsync_in (hsync_in),
    .hs_edge  (hs_edge),
    .pos_now  (pos_now)
  );

  avt_vblank #(.LW(LW)) u_vblank (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync_in   (vsync_in),
    .field_in   (field_in),
    .hs_edge    (hs_edge),
    .blank_off  (blank_off),
    .blank_dur  (blank_dur),
    .vs_edge    (vs_edge),
    .field_now  (field_now),
    .vblank_now (vblank_now)
  );

  avt_insert #(.PW(PW), .DW(DW)) u_insert (
    .clk        (clk),
    .rst_n      (rst_n),
    .pos_now    (pos_now),
    .start_pos  (start_pos),
    .stop_pos   (stop_pos),
    .blank_mask (blank_mask),
    .vblank_now (vblank_now),
    .field_now  (field_now),
    .vsync_in   (vsync_in),
    .pix_in     (pix_in),
    .code_now   (code_now),
    .status_q   (status_q),
    .pix_out    (pix_out),
    .de_out     (de_out),
    .vblank_out (vblank_out),
    .vsync_out  (vsync_out)
  );

endmodule

// File: rtl/avt_embsync_chk.sv
module avt_embsync_chk #(
  parameter int PW = 13,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vsync_in,
  input logic          vsync_out,
  input logic          de_out,
  input logic          vblank_out,
  input logic [DW-1:0] pix_out,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic          code_now,
  input logic          status_q,
  input logic          blank_mask,
  input logic [PW-1:0] start_pos,
  input logic [PW-1:0] stop_pos
);
  import avt_pkg::*;

  // R11
  vsync_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> vsync_out == $past(vsync_in));

  // R4
  code_no_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_now |=> !de_out);

  // R10
  mask_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_out |-> !($past(blank_mask) && vblank_out));

  // R3
  start_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_START_LO) |=> $stable(start_pos));

  // R3
  stop_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_STOP_LO) |=> $stable(stop_pos));

  // R8
  status_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q |-> (pix_out[DW-1] &&
                  pix_out[DW-5] == (pix_out[DW-3] ^ pix_out[DW-4]) &&
                  pix_out[DW-6] == (pix_out[DW-2] ^ pix_out[DW-4]) &&
                  pix_out[DW-7] == (pix_out[DW-2] ^ pix_out[DW-3]) &&
                  pix_out[DW-8] == (pix_out[DW-2] ^ pix_out[DW-3] ^ pix_out[DW-4])));

  // R8
  status_vmatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q |-> pix_out[DW-3] == vblank_out);

endmodule

bind avt_embsync_gen avt_embsync_chk #(.PW(PW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vsync_in   (vsync_in),
  .vsync_out  (vsync_out),
  .de_out     (de_out),
  .vblank_out (vblank_out),
  .pix_out    (pix_out),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .code_now   (code_now),
  .status_q   (status_q),
  .blank_mask (blank_mask),
  .start_pos  (start_pos),
  .stop_pos   (stop_pos)
);

// File: tb/avt_embsync_gen_test.sv
module avt_embsync_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0, vsync_in = 1'b0, field_in = 1'b0;
  logic [7:0] pix_in = '0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] pix_out;
  logic       de_out, vblank_out, vsync_out;

  avt_embsync_gen uut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .field_in(field_in), .pix_in(pix_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pix_out(pix_out), .de_out(de_out),
    .vblank_out(vblank_out), .vsync_out(vsync_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  string phase = "";

  // programmed settings as the bench believes them
  int sh_start = 'h12C, sh_stop = 'h62C, st_stage = 'h2C, sp_stage = 'h2C;
  bit sh_mask = 0;
  int sh_off[2] = '{5, 5};
  int sh_dur[2] = '{30, 30};

  // reference model state
  int m_pos = 8191, m_line = 0;
  bit m_field = 0, last_hs = 0, last_vs = 0;
  bit have_prev = 0;
  logic [7:0] e_word;
  bit e_de, e_vb, e_vs;
  string e_wtag, e_dtag;

  function automatic logic [7:0] ref_status(bit f, bit v, bit h);
    logic [7:0] w;
    w[0] = f ^ v ^ h; w[1] = f ^ v; w[2] = f ^ h; w[3] = v ^ h;
    w[4] = h; w[5] = v; w[6] = f; w[7] = 1'b1;
    return w;
  endfunction

  function automatic int eff_stop(int st, int sp);
    return ((sp - st) % 2 != 0) ? sp + 1 : sp;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_prev();
    if (have_prev) begin
      check(pix_out == e_word, {e_wtag, phase}, pix_out, e_word);
      check(de_out == e_de, {e_dtag, phase}, de_out, e_de);
      check(vblank_out == e_vb, {"R9 vblank", phase}, vblank_out, e_vb);
      check(vsync_out == e_vs, {"R11 vsync copy", phase}, vsync_out, e_vs);
    end
  endtask

  task automatic pix(bit hs, bit vs, bit fld, logic [7:0] d);
    int se, k;
    bit vb;
    @(negedge clk);
    compare_prev();
    hsync_in = hs; vsync_in = vs; field_in = fld; pix_in = d;
    if (vs && !last_vs) begin m_line = 0; m_field = fld; end
    else if (hs && !last_hs) m_line = (m_line < 1023) ? m_line + 1 : 1023;
    m_pos = (hs && !last_hs) ? 0 : ((m_pos < 8191) ? m_pos + 1 : 8191);
    last_hs = hs; last_vs = vs;
    vb = (m_line >= sh_off[m_field]) && (m_line < sh_off[m_field] + sh_dur[m_field]);
    se = eff_stop(sh_start, sh_stop);
    if (m_pos >= se && m_pos < se + 4) begin
      k = m_pos - se;
      e_word = (k == 0) ? 8'hFF : (k == 3) ? ref_status(m_field, vb, 1'b1) : 8'h00;
      e_wtag = (k == 3) ? "R8 end status" : "R7 end code";
    end else if (m_pos >= sh_start - 4 && m_pos < sh_start) begin
      k = m_pos - (sh_start - 4);
      e_word = (k == 0) ? 8'hFF : (k == 3) ? ref_status(m_field, vb, 1'b0) : 8'h00;
      e_wtag = (k == 3) ? "R8 start status" : "R6 start code";
    end else begin
      e_word = d;
      e_wtag = "R12 pass-through";
    end
    e_de  = (m_pos >= sh_start) && (m_pos < se) && !(sh_mask && vb);
    e_dtag = (sh_mask && vb) ? "R10 masked de" : (se != sh_stop ? "R5 odd span de" : "R4 de");
    e_vb  = vb;
    e_vs  = vs;
    have_prev = 1;
  endtask

  task automatic flush();
    @(negedge clk);
    compare_prev();
    have_prev = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    flush();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic prog_start(int v, bit mask);
    wr(3'd0, v[7:0]); st_stage = v & 'hFF;
    wr(3'd1, {2'b00, mask, v[12:8]});
    sh_start = v; sh_mask = mask;
  endtask

  task automatic prog_stop(int v);
    wr(3'd2, v[7:0]); sp_stage = v & 'hFF;
    wr(3'd3, {3'b000, v[12:8]});
    sh_stop = v;
  endtask

  task automatic prog_field(int f, int off, int dur);
    wr(3'(4 + f), 8'(off)); sh_off[f] = off;
    wr(3'(6 + f), 8'(dur)); sh_dur[f] = dur;
  endtask

  task automatic line(int len, bit rnd);
    for (int px = 0; px < len; px++) pix(px < 8, 1'b0, 1'b0, rnd ? 8'($urandom) : 8'(px));
  endtask

  task automatic frame(int nl, int len, bit fld, int vs_px);
    for (int ln = 0; ln < nl; ln++)
      for (int px = 0; px < len; px++)
        pix(px < 8, (ln == 0 && px >= vs_px) || ln == 1, fld, 8'($urandom));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int st, sp;
    void'($urandom(32'd2718));
    // R1 outputs held low in reset
    repeat (3) @(negedge clk);
    check(pix_out == 8'h00, "R1 reset pix_out", pix_out, 0);
    check(de_out == 1'b0, "R1 reset de_out", de_out, 0);
    check(vblank_out == 1'b0, "R1 reset vblank_out", vblank_out, 0);
    check(vsync_out == 1'b0, "R1 reset vsync_out", vsync_out, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 no codes or de before the first horizontal edge
    phase = " [R2 before first hsync]";
    for (int i = 0; i < 20; i++) pix(1'b0, 1'b0, 1'b0, 8'(i));
    // R1 default start/stop on a long line
    phase = " [R1 default span]";
    line(1700, 1'b1);
    flush();
    prog_start(20, 1'b0);
    prog_stop(60);
    // R1 default blanking window (offset 5, length 30)
    phase = " [R1 default blanking]";
    frame(40, 80, 1'b0, 0);
    // R3 low byte alone does not move start
    phase = " [R3 low byte only]";
    wr(3'd0, 8'd30); st_stage = 30;
    line(80, 1'b1); line(80, 1'b1);
    wr(3'd1, 8'h00); sh_start = st_stage; sh_mask = 0;
    phase = " [R3 high byte commit]";
    line(80, 1'b1);
    // R5 odd span
    prog_stop(61);
    phase = " [R5 odd span]";
    line(80, 1'b1); line(80, 1'b1);
    // R9 distinct field windows
    prog_field(0, 2, 3);
    prog_field(1, 1, 5);
    phase = " [R9 field 0]";
    frame(10, 80, 1'b0, 0);
    phase = " [R9 field 1]";
    frame(10, 80, 1'b1, 0);
    // R9 vertical edge mid-line
    phase = " [R9 mid-line vsync]";
    frame(10, 80, 1'b1, 40);
    // R10 mask on
    prog_start(30, 1'b1);
    phase = " [R10 mask on]";
    frame(10, 80, 1'b0, 0);
    frame(10, 80, 1'b1, 3);
    // random frames
    for (int r = 0; r < 16; r++) begin
      st = 4 + 2 * int'($urandom_range(0, 13));
      sp = st + int'($urandom_range(2, 40));
      prog_start(st, 1'($urandom_range(0, 1)));
      prog_stop(sp);
      prog_field(0, $urandom_range(0, 6), $urandom_range(0, 6));
      prog_field(1, $urandom_range(0, 6), $urandom_range(0, 6));
      phase = $sformatf(" [R4 random %0d]", r);
      frame(10, 80, 1'($urandom_range(0, 1)), $urandom_range(0, 60));
    end
    flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule